// File: doc/BRIEF.md
# Byte Write Qualification and Bus Control

This block sits between the strobe, select and write pins of a synchronous burst memory and its storage core. On every clock it classifies the current cycle as idle, read, full-word write or partial write, and turns the write pins into one write strobe per byte lane. It also decides whether the shared data bus may be driven with read data in this cycle, and it keeps track of whether an access was opened by the processor strobe or by the controller strobe.

Decisions are combinational over the pins present before the clock edge, and the access state is registered on that edge. The storage core writes the lanes named by the strobes on that same edge. A cycle that opens an access on the processor strobe never writes. The following cycle may write. A cycle that opens an access on the controller strobe writes at once if the write pins request it. Any detected write turns the bus drivers off, whatever the output enable pin says.

Top module: `bwq_ctrl`

## Requirements
- R1: When the global write pin `gw_ni` is low in a cycle that may write, all byte strobes are high and the byte enable and byte selects are ignored.
- R2: With `gw_ni` high, strobe `we_o[i]` is high only when `bwe_ni` is low and `bw_ni[i]` is low. When `bwe_ni` is high, no strobe is raised.
- R3: A cycle in which the device is selected (`cs1_ni` low, `cs2_i` high, `cs3_ni` low) and `adsp_ni` is low opens a processor access. It raises no strobe, and `phase_o` becomes 1 on the next edge.
- R4: In a continuation cycle (both strobes high, or `adsp_ni` low with `cs1_ni` high and `adsc_ni` high) that follows an open access, the write pins are honoured as in R1/R2.
- R5: A selected cycle with `adsc_ni` low and no effective processor strobe opens a controller access. It writes in that same cycle per R1/R2, and `phase_o` becomes 2.
- R6: `adsc_ni` is ignored while the processor strobe is effective (`adsp_ni` low and `cs1_ni` low). Such a cycle behaves as in R3.
- R7: `dq_oe_o` is low in every cycle in which any strobe is high, regardless of `oe_ni`.
- R8: `dq_oe_o` is high exactly when `oe_ni` is low, the cycle is an access (opening or continuation), and no strobe is high.
- R9: With `phase_o` at 0 and no access being opened, no strobe is high, `dq_oe_o` is low and `cyc_o` is 0.
- R10: A cycle with an effective strobe (`adsc_ni` low, or `adsp_ni` low with `cs1_ni` low) while the device is not selected closes the access, so `phase_o` becomes 0.
- R11: `cyc_o` is 0 when there is no access, 1 for a read access, 2 when all strobes are high and 3 when some but not all are high.
- R12: After reset `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | NUM_BYTES | Byte selects, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_o | output | NUM_BYTES | Per-lane write strobes for this cycle |
| dq_oe_o | output | 1 | Read data drive enable for the shared bus |
| cyc_o | output | 2 | Cycle kind: 0 none, 1 read, 2 full write, 3 partial write |
| phase_o | output | 2 | Open access: 0 none, 1 processor, 2 controller |

## Verification
The bench builds the block with its default of four byte lanes. With four lanes, every one of the sixteen byte select patterns is reachable by random stimulus, and the split between full and partial writes shows up often. Selects are biased toward a selected device, so processor openings, controller openings, continuations and deselects follow each other in many orders. The case where both strobes are low and the case where the processor strobe is masked by a high `cs1_ni` are exercised on purpose.

// File: rtl/bwq_pkg.sv
package bwq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROC = 2'd1,
    PH_CTRL = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    CY_NONE = 2'd0,
    CY_READ = 2'd1,
    CY_FULL = 2'd2,
    CY_PART = 2'd3
  } cyc_e;
endpackage

// File: rtl/bwq_byte_decode.sv
module bwq_byte_decode #(
  parameter int NUM_BYTES = 4
) (
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  output logic [NUM_BYTES-1:0] mask_o
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    // global write overrides lane selects
    assign mask_o[i] = ~gw_ni | (~bwe_ni & ~bw_ni[i]);
  end
endmodule

// File: rtl/bwq_access_track.sv
module bwq_access_track
  import bwq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  input  logic   adsp_eff_i,
  input  logic   adsc_ni,
  output logic   proc_start_o,
  output logic   ctrl_start_o,
  output logic   cont_o,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;
  logic   deselect;

  assign proc_start_o = sel_i & adsp_eff_i;
  assign ctrl_start_o = sel_i & ~adsc_ni & ~adsp_eff_i;
  assign deselect     = ~sel_i & (adsp_eff_i | ~adsc_ni);
  assign cont_o       = (phase_q != PH_IDLE) & ~adsp_eff_i & adsc_ni;

  always_comb begin
    phase_d = phase_q;
    if (proc_start_o)      phase_d = PH_PROC;
    else if (ctrl_start_o) phase_d = PH_CTRL;
    else if (deselect)     phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_deselect_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deselect |=> phase_q == PH_IDLE);
  assert_proc_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_start_o |=> phase_q == PH_PROC);
  assert_ctrl_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_start_o |=> phase_q == PH_CTRL);
  assert_one_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(proc_start_o && ctrl_start_o));
endmodule

// File: rtl/bwq_ctrl.sv
module bwq_ctrl
  import bwq_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs1_ni,
  input  logic                 cs2_i,
  input  logic                 cs3_ni,
  input  logic                 adsp_ni,
  input  logic                 adsc_ni,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic                 oe_ni,
  output logic [NUM_BYTES-1:0] we_o,
  output logic                 dq_oe_o,
  output logic [1:0]           cyc_o,
  output logic [1:0]           phase_o
);
  localparam logic [NUM_BYTES-1:0] ALL_LANES = '1;

  logic                 sel, adsp_eff;
  logic                 proc_start, ctrl_start, cont, access_now, wr_ok;
  logic [NUM_BYTES-1:0] mask;
  phase_e               phase;
  cyc_e                 cyc;

  assign sel      = ~cs1_ni & cs2_i & ~cs3_ni;
  assign adsp_eff = ~adsp_ni & ~cs1_ni;  // processor strobe masked by cs1

  bwq_byte_decode #(.NUM_BYTES(NUM_BYTES)) u_decode (
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .bw_ni  (bw_ni),
    .mask_o (mask)
  );

  bwq_access_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel),
    .adsp_eff_i   (adsp_eff),
    .adsc_ni      (adsc_ni),
    .proc_start_o (proc_start),
    .ctrl_start_o (ctrl_start),
    .cont_o       (cont),
    .phase_o      (phase)
  );

  // write pins are ignored on the cycle opening a processor access
  assign wr_ok      = ctrl_start | cont;
  assign access_now = proc_start | wr_ok;
  assign we_o       = wr_ok ? mask : '0;
  assign dq_oe_o    = ~oe_ni & access_now & ~(|we_o);

  always_comb begin
    if (!access_now)            cyc = CY_NONE;
    else if (we_o == '0)        cyc = CY_READ;
    else if (we_o == ALL_LANES) cyc = CY_FULL;
    else                        cyc = CY_PART;
  end

  assign cyc_o   = cyc;
  assign phase_o = phase;

  assert_hiz_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0) |-> !dq_oe_o);
  assert_gw_all_lanes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0 && !gw_ni) |-> (we_o == ALL_LANES));
  assert_proc_first_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !cs1_ni && cs2_i && !cs3_ni) |-> (we_o == '0));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0 && adsc_ni && (adsp_ni || cs1_ni)) |-> (we_o == '0 && !dq_oe_o));
  assert_bwe_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |-> (we_o == '0));
  assert_read_kind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (cyc_o == 2'd1));
endmodule

// File: tb/bwq_ctrl_test.sv
`timescale 1ns/1ps
module bwq_ctrl_test;
  localparam int NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs1_n = 1, cs2 = 0, cs3_n = 1, adsp_n = 1, adsc_n = 1, gw_n = 1, bwe_n = 1, oe_n = 1;
  logic [NB-1:0] bw_n = '1;
  logic [NB-1:0] we;
  logic          dq_oe;
  logic [1:0]    cyc, phase;

  int n_checks = 0, n_fail = 0;
  logic [1:0] m_phase = 2'd0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bwq_ctrl #(.NUM_BYTES(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs1_ni(cs1_n), .cs2_i(cs2), .cs3_ni(cs3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n),
    .oe_ni(oe_n), .we_o(we), .dq_oe_o(dq_oe), .cyc_o(cyc), .phase_o(phase));

  function automatic logic [NB-1:0] lanes(input logic g, input logic b, input logic [NB-1:0] s);
    if (!g) return '1;
    if (b) return '0;
    return ~s;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // checks outputs for current inputs, then advances the model across the edge
  task automatic step(input string tag);
    logic sel, pe, ps, cstart, cont, desel, acc;
    logic [NB-1:0] e_we;
    int e_cyc;
    sel    = !cs1_n && cs2 && !cs3_n;
    pe     = !adsp_n && !cs1_n;
    ps     = sel && pe;
    cstart = sel && !adsc_n && !pe;
    desel  = !sel && (pe || !adsc_n);
    cont   = (m_phase != 0) && !pe && adsc_n;
    acc    = ps || cstart || cont;
    e_we   = (cstart || cont) ? lanes(gw_n, bwe_n, bw_n) : '0;
    if (!acc) e_cyc = 0;
    else if (e_we == '0) e_cyc = 1;
    else if (e_we == '1) e_cyc = 2;
    else e_cyc = 3;
    #1;
    check(tag, "we", int'(we), int'(e_we));
    check(tag, "dq_oe", int'(dq_oe), int'(!oe_n && acc && e_we == '0));
    check(tag, "cyc", int'(cyc), e_cyc);
    check(tag, "phase", int'(phase), int'(m_phase));
    if (ps) m_phase = 2'd1;
    else if (cstart) m_phase = 2'd2;
    else if (desel) m_phase = 2'd0;
    @(negedge clk);
  endtask

  task automatic drive(input logic c1, input logic c2, input logic c3, input logic p,
                       input logic c, input logic g, input logic b,
                       input logic [NB-1:0] s, input logic o);
    cs1_n = c1; cs2 = c2; cs3_n = c3; adsp_n = p; adsc_n = c;
    gw_n = g; bwe_n = b; bw_n = s; oe_n = o;
  endtask

  initial begin
    int unsigned r;
    void'($urandom(32'd20240517));
    #1;
    check("R12", "phase in reset", int'(phase), 0);
    check("R12", "we in reset", int'(we), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1, 0, 1, 1, 1, 1, 1, '1, 0); step("R9 idle");
    drive(0, 1, 0, 0, 1, 0, 0, 4'b0000, 0); step("R3 proc open ignores gw");
    drive(0, 1, 0, 1, 1, 0, 1, '1, 0); step("R1/R4 gw full write, R7 hiz");
    drive(0, 1, 0, 1, 1, 1, 0, 4'b1010, 0); step("R2/R11 partial");
    drive(0, 1, 0, 1, 1, 1, 1, 4'b0000, 0); step("R2/R8 bwe off read");
    drive(1, 1, 0, 0, 1, 1, 0, 4'b0110, 1); step("R4 cs1-masked adsp continues");
    drive(0, 1, 0, 1, 0, 1, 0, 4'b1110, 0); step("R5 ctrl write first cycle");
    drive(0, 1, 0, 1, 1, 1, 1, '1, 1); step("R8 oe high no drive");
    drive(0, 1, 0, 0, 0, 0, 0, 4'b0000, 0); step("R6 adsc ignored under adsp");
    drive(1, 0, 1, 1, 0, 0, 0, 4'b0000, 0); step("R10 deselect");
    drive(0, 1, 0, 1, 1, 0, 0, 4'b0000, 0); step("R9 idle after deselect");
    drive(0, 1, 0, 1, 0, 1, 1, '1, 0); step("R5/R8 ctrl read");
    drive(0, 0, 0, 0, 1, 1, 1, '1, 0); step("R10 proc strobe unselected");
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      drive((r[3:0] == 0), (r[7:4] != 0), (r[11:8] == 0), (r[13:12] != 0), (r[15:14] != 0),
            (r[18:16] != 0), r[19], r[23:20], r[24]);
      step("R1/R2/R4/R5/R7/R8/R11 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule